// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block generates four independent pulse-width modulated outputs from one input clock. Each channel divides the clock by a programmable prescale factor, counts a programmable number of prescaled steps per period, and holds its output at the active level for a programmable number of those steps at the start of each period. The polarity of each channel can be set. Each channel's drive can be push-pull, or open-drain, where the pin is driven only while it is low.

Software configures the block through a plain single-cycle register port: a valid strobe, a write flag, a byte address and 32-bit data. Read data appears one cycle after a read strobe. New timing values reach a running channel only at a period boundary. A channel's enable is rate-limited: once it has changed, a further change is held back for a fixed number of clocks, so that the output stage can settle.

Top module: `pwm4_ctrl`

## Requirements
- R1: Word registers sit at these byte offsets: control at 0x00, period of channel n at 0x04+8n, duty of channel n at 0x08+8n, and the shared prescale register at 0x24. Period and duty keep only their low 16 bits, and unused bits read as 0. An access whose address bits 1:0 are not 00 is ignored. Read data is valid in the cycle after the read strobe and does not change otherwise.
- R2: In the control register, bit n enables channel n, bit 8+n sets its polarity and bit 15+n sets its drive type. A write of 0xFFFFFFF0 reads back as 0x00078F00.
- R3: The prescale field of channel n is 6 bits wide and starts at bit (3-n)*6. A running channel repeats every (prescale+1)*period clocks.
- R4: In each period the active level lasts (prescale+1)*min(duty, period) clocks. A duty of 0 keeps the output inactive, and a duty at or above the period keeps it active.
- R5: With a period value of 0 or 1 an enabled channel holds its output at the inactive level.
- R6: Polarity 1 makes the active level 1 and the inactive level 0. Polarity 0 swaps the two levels.
- R7: With drive type 0, output-enable is always 1. With drive type 1, output-enable is 1 exactly when the output is 0.
- R8: While a channel is disabled, its output sits at the inactive level and its counters are cleared. If a write sets the enable at clock edge k, the channel starts a new period at edge k+1, beginning with its active portion.
- R9: Once a channel's enable has taken effect, the opposite change is deferred until SETTLE_CYC clocks have passed.
- R10: New period, duty and prescale values written to a running channel take effect at its next period boundary. A disabled channel takes them at once.
- R11: After reset all registers read 0, so every output is 1 (inactive, inverted polarity) and every output-enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the counters and registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pwm_out | output | 4 | Output level per channel |
| pwm_oe | output | 4 | Output enable per channel |

## Verification
The assertions assume that reset is applied before the first access and that every access is a single-cycle strobe whose address lies in the register map. The stimulus follows these rules. It uses only aligned mapped offsets, except for one unaligned write that checks R1. Before a channel is reconfigured, the bench waits out twice the settle window, so each measured enable change takes effect at once and no deferred toggle is still pending. Timing is measured over windows of exactly one period of steady operation, so the counts do not depend on the phase at which counting starts.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;

  localparam int NCH     = 4;
  localparam int EN_LSB  = 0;
  localparam int POL_LSB = 8;
  localparam int TYP_LSB = 15;

  localparam logic [3:0] W_CTRL = 4'd0;
  localparam logic [3:0] W_PSC  = 4'd9;

  // word index of the period register of channel ch
  function automatic logic [3:0] per_word(int ch);
    return 4'(1 + 2 * ch);
  endfunction

  // word index of the duty register of channel ch
  function automatic logic [3:0] duty_word(int ch);
    return 4'(2 + 2 * ch);
  endfunction

  // lowest bit of a channel's prescale field; channel 0 sits highest
  function automatic int psc_lsb(int ch, int w);
    return (NCH - 1 - ch) * w;
  endfunction

  // pin level from the active flag and the polarity bit
  function automatic logic drive_level(logic active, logic pol);
    return pol ? active : !active;
  endfunction

endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
  import pwm4_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_valid,
  input  logic                        bus_write,
  input  logic [5:0]                  bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic [NCH-1:0]              en_req,
  output logic [NCH-1:0]              pol,
  output logic [NCH-1:0]              typ,
  output logic [NCH-1:0][CNT_W-1:0]   per_sh,
  output logic [NCH-1:0][CNT_W-1:0]   duty_sh,
  output logic [NCH-1:0][PS_W-1:0]    psc_sh
);

  logic [3:0]  word;
  logic        hit;
  logic        wr_hit;
  logic        rd_hit;
  logic [31:0] rd_next;
  logic [31:0] rdata_q;
  wire         unused_wdata = ^bus_wdata[31:24];

  assign word   = bus_addr[5:2];
  assign hit    = bus_valid && (bus_addr[1:0] == 2'b00);
  assign wr_hit = hit && bus_write;
  assign rd_hit = hit && !bus_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_req  <= '0;
      pol     <= '0;
      typ     <= '0;
      per_sh  <= '0;
      duty_sh <= '0;
      psc_sh  <= '0;
    end else if (wr_hit) begin
      if (word == W_CTRL) begin
        for (int c = 0; c < NCH; c++) begin
          en_req[c] <= bus_wdata[EN_LSB + c];
          pol[c]    <= bus_wdata[POL_LSB + c];
          typ[c]    <= bus_wdata[TYP_LSB + c];
        end
      end
      if (word == W_PSC) begin
        for (int c = 0; c < NCH; c++) begin
          psc_sh[c] <= bus_wdata[psc_lsb(c, PS_W) +: PS_W];
        end
      end
      for (int c = 0; c < NCH; c++) begin
        if (word == per_word(c))  per_sh[c]  <= bus_wdata[CNT_W-1:0];
        if (word == duty_word(c)) duty_sh[c] <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (word == W_CTRL) begin
      for (int c = 0; c < NCH; c++) begin
        rd_next[EN_LSB + c]  = en_req[c];
        rd_next[POL_LSB + c] = pol[c];
        rd_next[TYP_LSB + c] = typ[c];
      end
    end else if (word == W_PSC) begin
      for (int c = 0; c < NCH; c++) begin
        rd_next[psc_lsb(c, PS_W) +: PS_W] = psc_sh[c];
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (word == per_word(c))  rd_next[CNT_W-1:0] = per_sh[c];
        if (word == duty_word(c)) rd_next[CNT_W-1:0] = duty_sh[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_hit) rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> $stable(bus_rdata)); // R1

endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan #(
  parameter int CNT_W      = 16,
  parameter int PS_W       = 6,
  parameter int SETTLE_CYC = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_req,
  input  logic             pol,
  input  logic             typ,
  input  logic [CNT_W-1:0] per_sh,
  input  logic [CNT_W-1:0] duty_sh,
  input  logic [PS_W-1:0]  psc_sh,
  output logic             pin_out,
  output logic             pin_oe
);
  import pwm4_pkg::*;

  localparam int               SET_W   = $clog2(SETTLE_CYC + 2);
  localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(2);

  // true when the step after count c closes a period of length p
  function automatic logic last_step(logic [CNT_W-1:0] c, logic [CNT_W-1:0] p);
    return ({1'b0, c} + 1'b1) >= {1'b0, p};
  endfunction

  logic             run_en;
  logic [SET_W-1:0] settle_cnt;
  logic [PS_W-1:0]  psc_cnt;
  logic [CNT_W-1:0] per_cnt;
  logic [CNT_W-1:0] act_per;
  logic [CNT_W-1:0] act_duty;
  logic [PS_W-1:0]  act_psc;

  // named internal events
  logic en_change;
  logic psc_tick;
  logic period_end;
  logic per_valid;
  logic active;
  logic level;

  assign en_change  = (en_req != run_en) && (settle_cnt == '0);
  assign psc_tick   = (psc_cnt == act_psc);
  assign period_end = run_en && psc_tick && last_step(per_cnt, act_per);
  assign per_valid  = (act_per >= MIN_PER);
  assign active     = run_en && per_valid && (per_cnt < act_duty);
  assign level      = drive_level(active, pol);

  // enable with settle window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en     <= 1'b0;
      settle_cnt <= '0;
    end else if (en_change) begin
      run_en     <= en_req;
      settle_cnt <= SET_W'(SETTLE_CYC);
    end else if (settle_cnt != '0) begin
      settle_cnt <= settle_cnt - 1'b1;
    end
  end

  // prescaler, period counter and active copies of the settings
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_cnt  <= '0;
      per_cnt  <= '0;
      act_per  <= '0;
      act_duty <= '0;
      act_psc  <= '0;
    end else if (!run_en) begin
      psc_cnt  <= '0;
      per_cnt  <= '0;
      act_per  <= per_sh;
      act_duty <= duty_sh;
      act_psc  <= psc_sh;
    end else if (psc_tick) begin
      psc_cnt <= '0;
      if (period_end) begin
        per_cnt  <= '0;
        act_per  <= per_sh;
        act_duty <= duty_sh;
        act_psc  <= psc_sh;
      end else begin
        per_cnt <= per_cnt + 1'b1;
      end
    end else begin
      psc_cnt <= psc_cnt + 1'b1;
    end
  end

  assign pin_out = level;
  assign pin_oe  = typ ? !level : 1'b1;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && per_valid) |-> (per_cnt < act_per)); // R3
  AST_PSC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    psc_cnt <= act_psc); // R3
  AST_BAD_PER_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !per_valid |-> (per_cnt == '0)); // R5
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (per_cnt == '0 && psc_cnt == '0)); // R8
  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_cnt != '0) |=> $stable(run_en)); // R9
  AST_LATCH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && $past(run_en) && !$past(period_end))
      |-> ($stable(act_duty) && $stable(act_per) && $stable(act_psc))); // R10
  AST_OD_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    typ |-> (pin_oe != pin_out)); // R7

endmodule

// File: rtl/pwm4_ctrl.sv
module pwm4_ctrl
  import pwm4_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PS_W       = 6,
  parameter int SETTLE_CYC = 100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_valid,
  input  logic           bus_write,
  input  logic [5:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] pwm_out,
  output logic [NCH-1:0] pwm_oe
);

  logic [NCH-1:0]            en_req;
  logic [NCH-1:0]            pol;
  logic [NCH-1:0]            typ;
  logic [NCH-1:0][CNT_W-1:0] per_sh;
  logic [NCH-1:0][CNT_W-1:0] duty_sh;
  logic [NCH-1:0][PS_W-1:0]  psc_sh;

  pwm4_regs #(.CNT_W(CNT_W), .PS_W(PS_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .en_req    (en_req),
    .pol       (pol),
    .typ       (typ),
    .per_sh    (per_sh),
    .duty_sh   (duty_sh),
    .psc_sh    (psc_sh)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm4_chan #(.CNT_W(CNT_W), .PS_W(PS_W), .SETTLE_CYC(SETTLE_CYC)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_req  (en_req[c]),
      .pol     (pol[c]),
      .typ     (typ[c]),
      .per_sh  (per_sh[c]),
      .duty_sh (duty_sh[c]),
      .psc_sh  (psc_sh[c]),
      .pin_out (pwm_out[c]),
      .pin_oe  (pwm_oe[c])
    );
  end

  AST_PP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    ((~typ & ~pwm_oe) == '0)); // R7

endmodule

// File: tb/pwm4_ctrl_tb.sv
module pwm4_ctrl_tb;

  localparam int S = 12;

  typedef struct packed {
    logic [1:0]  ch;
    logic [15:0] per;
    logic [15:0] duty;
    logic [5:0]  ps;
    logic        pol;
    logic        typ;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'd10, 16'd3, 6'd0, 1'b1, 1'b0},  // R4 basic
    '{2'd1, 16'd8,  16'd5, 6'd2, 1'b1, 1'b0},  // R3 prescale ch1
    '{2'd2, 16'd12, 16'd4, 6'd1, 1'b0, 1'b0},  // R6 inverted
    '{2'd3, 16'd6,  16'd2, 6'd3, 1'b1, 1'b1},  // R7 open drain, R3 ch3
    '{2'd0, 16'd7,  16'd0, 6'd1, 1'b1, 1'b0},  // R4 duty 0
    '{2'd1, 16'd5,  16'd9, 6'd0, 1'b1, 1'b1},  // R4 duty above period
    '{2'd2, 16'd9,  16'd9, 6'd0, 1'b0, 1'b1},  // R4 duty equal period
    '{2'd3, 16'd1,  16'd1, 6'd0, 1'b1, 1'b0},  // R5 period 1
    '{2'd0, 16'd0,  16'd5, 6'd2, 1'b1, 1'b0},  // R5 period 0
    '{2'd2, 16'd20, 16'd7, 6'd5, 1'b1, 1'b0}   // R3 large prescale
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;
  logic [3:0]  pwm_oe;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pwm4_ctrl #(.SETTLE_CYC(S)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .pwm_oe    (pwm_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_len(input int ch, output int n);
    n = 0;
    while (pwm_out[ch] && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_rise(input int ch);
    logic prev;
    int guard;
    prev = pwm_out[ch];
    guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if ((pwm_out[ch] && !prev) || guard > 1000) break;
      prev = pwm_out[ch];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    vec_t v;
    int total, act, hi, oe, per_eff, n;

    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 out", {28'd0, pwm_out}, 32'hF);
    chk("R11 oe", {28'd0, pwm_oe}, 32'hF);
    rd(6'h00, d); chk("R11 ctrl", d, 32'h0);
    rd(6'h04, d); chk("R11 period0", d, 32'h0);

    // R1 unaligned write ignored, masking, prescale width
    wr(6'h05, 32'h1111);
    rd(6'h04, d); chk("R1 unaligned", d, 32'h0);
    wr(6'h14, 32'hABCD1234);
    rd(6'h14, d); chk("R1 period2 mask", d, 32'h1234);
    wr(6'h10, 32'h5555FFFF);
    rd(6'h10, d); chk("R1 duty1 mask", d, 32'hFFFF);
    wr(6'h24, 32'hFFFFFFFF);
    rd(6'h24, d); chk("R1 prescale", d, 32'h00FFFFFF);

    // R2 control layout, all disabled: R6 inactive 0, R7 open-drain drives
    wr(6'h00, 32'hFFFFFFF0);
    rd(6'h00, d); chk("R2 ctrl readback", d, 32'h00078F00);
    chk("R6 inactive level", {28'd0, pwm_out}, 32'h0);
    chk("R7 od enable low", {28'd0, pwm_oe}, 32'hF);
    wr(6'h00, 32'h0);

    // vector table: one steady period per entry (R3 R4 R5 R6 R7 R10)
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      wr(6'h00, 32'h0);
      idle(2 * S + 6);
      wr(6'(4 + 8 * v.ch), {16'd0, v.per});
      wr(6'(8 + 8 * v.ch), {16'd0, v.duty});
      wr(6'h24, 32'(v.ps) << ((3 - v.ch) * 6));
      wr(6'h00, (32'd1 << v.ch) | (v.pol ? 32'h0F00 : 32'h0) | (v.typ ? 32'h78000 : 32'h0));
      idle(3);
      per_eff = (v.per < 2) ? 2 : int'(v.per);
      total = (int'(v.ps) + 1) * per_eff;
      act = (v.per >= 2) ? (int'(v.ps) + 1) * ((v.duty < v.per) ? int'(v.duty) : int'(v.per)) : 0;
      hi = 0; oe = 0;
      for (int k = 0; k < total; k++) begin
        @(negedge clk);
        if (pwm_out[v.ch]) hi++;
        if (pwm_oe[v.ch]) oe++;
      end
      chk($sformatf("R4 high count vec%0d", i), 32'(hi), 32'(v.pol ? act : total - act));
      chk($sformatf("R7 oe count vec%0d", i), 32'(oe),
          32'(v.typ ? total - (v.pol ? act : total - act) : total));
    end

    // R10 new duty waits for the period boundary
    wr(6'h00, 32'h0);
    idle(2 * S + 6);
    wr(6'h04, 32'd10);
    wr(6'h08, 32'd5);
    wr(6'h24, 32'h0);
    wr(6'h00, 32'h101);
    idle(2);
    wait_rise(0);
    wr(6'h08, 32'd2);
    run_len(0, n);
    chk("R10 current period keeps duty", 32'(n + 1), 32'd5);
    wait_rise(0);
    run_len(0, n);
    chk("R10 next period new duty", 32'(n), 32'd2);

    // R8 disable to inactive, then restart from period start
    wr(6'h00, 32'h100);
    idle(2 * S + 6);
    chk("R8 disabled inactive", {31'd0, pwm_out[0]}, 32'd0);
    wr(6'h00, 32'h101);
    chk("R8 not yet running", {31'd0, pwm_out[0]}, 32'd0);
    @(negedge clk);
    run_len(0, n);
    chk("R8 restart full duty", 32'(n), 32'd2);

    // R9 disable right after enable is deferred
    wr(6'h0C, 32'd4);
    wr(6'h10, 32'd8);
    wr(6'h00, 32'h302);
    wr(6'h00, 32'h300);
    idle(4);
    chk("R9 toggle deferred", {31'd0, pwm_out[1]}, 32'd1);
    idle(S + 4);
    chk("R9 toggle applied", {31'd0, pwm_out[1]}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule